// File: doc/BRIEF.md
# Bit-Field Extract and Insert Unit

This is a purely combinational 32-bit datapath unit for a small processor core. It performs three operations on a source word: unsigned field extract, signed field extract, and field insert. A single packed control word describes the operation. Its low bits give the field's starting bit and its width. Its upper bits carry the value to deposit on an insert. The control word comes either from a register or from a short immediate that is sign-extended before it reaches the unit.

One instruction class built on this unit covers many jobs: byte and halfword sign or zero extension, single-bit tests through the zero flag, clearing a contiguous run of bits, and setting a contiguous run of bits. A fourth select code passes the source word through unchanged. Instruction decode, the register file and immediate fetch are handled elsewhere.

Top module: `bitfield_unit`

## Requirements
- R1: Control word bits [4:0] hold the field's lowest bit position. Bits [8:5] hold the width code. Codes 1 to 15 mean that many bits, and code 0 means a 16-bit field.
- R2: `op` selects the function: 2'b00 unsigned extract, 2'b01 signed extract, 2'b10 insert, 2'b11 pass-through.
- R3: Unsigned extract moves the field down to bit 0 and clears every result bit above the field width.
- R4: Signed extract moves the field down to bit 0 and fills every higher result bit with the field's top bit. Width 8 at position 0 sign-extends a byte. Width code 0 at position 0 sign-extends a halfword.
- R5: Insert replaces the field in `src` with the low field-width bits of control bits [31:10]. All `src` bits outside the field reach the result unchanged.
- R6: A 10-bit immediate, sign-extended to 32 bits and used as the control word, deposits all zeros when its bit 9 is clear and all ones when bit 9 is set. Insert with such an immediate therefore clears or sets one contiguous run of bits.
- R7: `zero` is 1 exactly when `result` is 0. A width-1 extract therefore reports through `zero` whether the addressed bit is clear.
- R8: A field that runs past bit 31 ends at bit 31. Extract returns only the bits that exist, and signed extract takes its sign from src bit 31. Insert drops the deposit bits that would fall above bit 31.
- R9: Pass-through (op 2'b11) returns `src` unchanged, whatever the control word holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src | input | 32 | Source word |
| ctl | input | 32 | Packed control word: position, width code, deposit value |
| op | input | 2 | Function select |
| result | output | 32 | Result word |
| zero | output | 1 | Result-is-zero flag |

## Verification
Field truncation at bit 31 and sign extension can act on the same operation. A signed extract whose field crosses the top of the word must take its sign from bit 31, not from a bit that does not exist. The bench provokes this with directed cases at high positions with wide width codes, and with random positions and widths that often cross the edge. A bit-by-bit reference model judges each result. It counts only the bits that actually exist and fills the rest from the last bit it copied.

// File: rtl/bitfield_unit.sv
module bitfield_unit #(
  parameter int DW = 32,
  parameter int WW = 4
) (
  input  logic [DW-1:0] src,
  input  logic [DW-1:0] ctl,
  input  logic [1:0]    op,
  output logic [DW-1:0] result,
  output logic          zero
);
  localparam int PW = $clog2(DW);
  localparam int VL = PW + WW + 1;
  localparam int WMAX = 1 << WW;

  logic [PW-1:0] pos;
  logic [WW-1:0] wcode;
  logic [PW:0]   wid;
  logic [PW+1:0] top_sum;
  logic [PW:0]   eff;
  logic [PW-1:0] sidx;
  logic [DW-1:0] lowmask, effmask, fmask, shifted, ext_u, ext_s, deposit, ins;

  assign pos     = ctl[PW-1:0];
  assign wcode   = ctl[PW+WW-1:PW];
  assign wid     = (wcode == '0) ? (PW+1)'(WMAX) : (PW+1)'(wcode);
  assign top_sum = (PW+2)'(pos) + (PW+2)'(wid);
  assign eff     = (top_sum > (PW+2)'(DW)) ? (PW+1)'(DW) - (PW+1)'(pos) : wid;
  assign sidx    = PW'(eff - 1'b1);

  assign lowmask = (DW'(1) << wid) - DW'(1);
  assign effmask = (DW'(1) << eff) - DW'(1);
  assign fmask   = lowmask << pos;

  assign shifted = src >> pos;
  assign ext_u   = shifted & lowmask;
  assign ext_s   = ext_u | (shifted[sidx] ? ~effmask : '0);

  assign deposit = ((ctl >> VL) << pos) & fmask;
  assign ins     = (src & ~fmask) | deposit;

  always_comb begin
    case (op)
      2'b00:   result = ext_u;
      2'b01:   result = ext_s;
      2'b10:   result = ins;
      default: result = src;
    endcase
  end

  assign zero = (result == '0);
endmodule

module bitfield_unit_chk #(
  parameter int DW = 32
) (
  input logic [DW-1:0] src,
  input logic [DW-1:0] ctl,
  input logic [1:0]    op,
  input logic [DW-1:0] result,
  input logic          zero
);
  int w, p, n;
  logic [DW-1:0] m, fm;

  always_comb begin
    p = int'(ctl[4:0]);
    w = (ctl[8:5] == 4'd0) ? 16 : int'(ctl[8:5]);
    n = (p + w > DW) ? DW - p : w;
    m = (DW'(1) << n) - DW'(1);
    fm = m << p;

    a_r7_zero_flag: assert (zero == (result == '0));
    if (op == 2'b00)
      a_r3_uext_upper_clear: assert ((result & ~m) == '0);
    if (op == 2'b01)
      a_r4_sext_fill: assert ((($signed(result) >>> (n - 1)) == 0) ||
                              (($signed(result) >>> (n - 1)) == -1));
    if (op == 2'b10)
      a_r5_insert_outside_kept: assert (((result ^ src) & ~fm) == '0);
    if (op == 2'b11)
      a_r9_pass_through: assert (result == src);
  end
endmodule

bind bitfield_unit bitfield_unit_chk #(.DW(DW)) u_chk (
  .src(src), .ctl(ctl), .op(op), .result(result), .zero(zero)
);

// File: tb/bitfield_unit_tb.sv
module bitfield_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] src, ctl;
  logic [1:0]  op;
  logic [31:0] result;
  logic        zero;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bitfield_unit u_dut (.src(src), .ctl(ctl), .op(op), .result(result), .zero(zero));

  function automatic logic [31:0] simm10(input logic [9:0] x);
    return {{22{x[9]}}, x};
  endfunction

  function automatic logic [31:0] mkctl(input int p, input int wc, input logic [21:0] v);
    return {v, 1'b0, 4'(wc), 5'(p)};
  endfunction

  function automatic logic [31:0] model(input logic [31:0] s, input logic [31:0] c,
                                        input logic [1:0] o);
    logic [31:0] r;
    logic last;
    int p, w, taken;
    p = int'(c[4:0]);
    w = (c[8:5] == 0) ? 16 : int'(c[8:5]);
    r = '0;
    last = 1'b0;
    taken = 0;
    case (o)
      2'b00, 2'b01: begin
        for (int i = 0; i < w; i++)
          if (p + i < 32) begin
            r[i] = s[p+i];
            last = s[p+i];
            taken = i + 1;
          end
        if (o == 2'b01)
          for (int i = 0; i < 32; i++)
            if (i >= taken) r[i] = last;
      end
      2'b10: begin
        r = s;
        for (int i = 0; i < w; i++)
          if (p + i < 32) r[p+i] = c[10+i];
      end
      default: r = s;
    endcase
    return r;
  endfunction

  task automatic run(input logic [31:0] s, input logic [31:0] c, input logic [1:0] o,
                     input string tag);
    logic [31:0] exp;
    @(posedge clk);
    src <= s; ctl <= c; op <= o;
    @(negedge clk);
    exp = model(s, c, o);
    checks++;
    if (result !== exp) begin
      fails++;
      $display("FAIL %s result op=%0d src=%h ctl=%h got %h exp %h", tag, o, s, c, result, exp);
    end
    checks++;
    if (zero !== (exp == 0)) begin
      fails++;
      $display("FAIL R7 zero flag (%s) got %b exp %b", tag, zero, exp == 0);
    end
  endtask

  task automatic expect_val(input logic [31:0] exp, input string tag);
    checks++;
    if (result !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", tag, result, exp);
    end
  endtask

  initial begin
    src = '0; ctl = '0; op = 2'b00;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (result !== 32'h0 || zero !== 1'b1) begin
      fails++;
      $display("FAIL R7 idle state got %h/%b exp 0/1", result, zero);
    end

    run(32'h0000_0080, mkctl(0, 8, 0), 2'b01, "R4 byte sext");
    expect_val(32'hFFFF_FF80, "R4 byte sext value");
    run(32'h1234_8001, mkctl(0, 0, 0), 2'b01, "R4 half sext code0");
    expect_val(32'hFFFF_8001, "R4 half sext value");
    run(32'h1234_8001, mkctl(0, 0, 0), 2'b00, "R3 half zext code0");
    expect_val(32'h0000_8001, "R1 code0 width16");
    run(32'hABCD_1234, mkctl(8, 4, 0), 2'b00, "R3 nibble");
    expect_val(32'h0000_0002, "R1 position field");
    run(32'h8000_0000, mkctl(31, 1, 0), 2'b00, "R7 bit test set");
    run(32'h7FFF_FFFF, mkctl(31, 1, 0), 2'b00, "R7 bit test clear");
    run(32'h8000_0000, mkctl(28, 15, 0), 2'b01, "R8 sext past top");
    expect_val(32'hFFFF_FFF8, "R8 sign from bit 31");
    run(32'hF000_0000, mkctl(30, 0, 0), 2'b00, "R8 zext past top");
    expect_val(32'h0000_0003, "R8 truncated field");
    run(32'hFFFF_FFFF, mkctl(4, 8, 22'h0A5), 2'b10, "R5 insert value");
    expect_val(32'hFFFF_FA5F, "R5 insert value");
    run(32'h0000_0000, mkctl(30, 4, 22'h00F), 2'b10, "R8 insert past top");
    expect_val(32'hC000_0000, "R8 insert truncated");
    run(32'hFFFF_FFFF, {simm10(10'h000) & 32'hFFFF_FC00} | 32'd0 | {23'd0, 4'd6, 5'd3},
        2'b10, "R6 clear run");
    expect_val(32'hFFFF_FE07, "R6 clear run");
    run(32'h0000_0000, simm10({1'b1, 4'd5, 5'd2}), 2'b10, "R6 set run");
    expect_val(32'h0000_007C, "R6 set run");
    run(32'hDEAD_BEEF, 32'hFFFF_FFFF, 2'b11, "R9 pass");
    expect_val(32'hDEAD_BEEF, "R9 pass value");
    run(32'h0000_00F0, mkctl(4, 4, 0), 2'b01, "R2 signed select");
    run(32'h0000_00F0, mkctl(4, 4, 0), 2'b00, "R2 unsigned select");

    void'($urandom(32'd1234));
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] s, c;
      logic [1:0] o;
      s = $urandom();
      c = $urandom();
      if (k % 4 == 0) c = simm10(c[9:0]);
      if (k % 5 == 0) c[4:0] = 5'd24 + 5'($urandom_range(0, 7));
      o = 2'($urandom_range(0, 3));
      run(s, c, o, "R3 R4 R5 R8 R9 random");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #2_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule